// File: doc/BRIEF.md
# Configuration Cycle ID Select

This block keeps a one-hot identity register that serves as the chip select for configuration cycles on a multiplexed address/data bus. The register leaves reset with bit 25 set (0x0200_0000). Software can move it once after each reset by issuing a full-width I/O write to address zero whose data has exactly one bit set. A write that breaks any of these rules leaves the register alone and does not use up the one permitted load.

On each address phase, the block compares the upper address lines (bits 31 down to 12) with the same bits of the identity register. If the phase carries a configuration read or write command and any bit position matches, the block raises its select output. The select output then holds until the next address phase. The configuration space behind the select is not part of this block.

Top module: `cfgid_select`

## Requirements
- R1: While reset is active and in the first cycle after it, `idsel_o` reads 0x0200_0000 and `cfg_sel_o` reads 0.
- R2: An address phase with command code 4'b0011 (I/O write) and address 0x0000_0000 arms a load. The next data strobe then loads `ad_i` into `idsel_o` at that clock edge, provided that strobe is the first data strobe since the address phase, `cbe_n_i` equals 4'b0000 (all four byte lanes active), and the data is one-hot.
- R3: Data with zero set bits, or with two or more set bits, leaves `idsel_o` unchanged.
- R4: The register is not loaded, and the one-time load stays available, when any of these is true: the address is not zero, the byte enables are not all active, or the command is anything other than I/O write.
- R5: Once a load has taken place, later writes that would otherwise qualify leave `idsel_o` unchanged until the next reset.
- R6: A load is only taken from the first data strobe after an address phase. Later data strobes in the same burst are ignored. A data strobe that arrives in the same cycle as an address strobe is ignored as a data phase.
- R7: On an address strobe, `cfg_sel_o` is set at that clock edge. It becomes 1 only if the command code is 4'b1010 (configuration read) or 4'b1011 (configuration write) and `ad_i[31:12]` shares at least one set bit with `idsel_o[31:12]`. Otherwise it becomes 0. It holds this value until the next address strobe.
- R8: Bits 11 to 0 of the identity register never produce a select. If the register has been loaded with a bit below 12, configuration cycles never assert `cfg_sel_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_i | input | 32 | Multiplexed address/data lines |
| cbe_n_i | input | 4 | Command (address phase) or active-low byte enables (data phase) |
| addr_strobe_i | input | 1 | Marks an address phase |
| data_strobe_i | input | 1 | Marks a data phase |
| idsel_o | output | 32 | Current identity-select register |
| cfg_sel_o | output | 1 | Configuration-cycle chip select |

## Verification
A corrupted identity register shows up on `idsel_o` at the clock edge right after the faulty write. It also changes the answer of the next configuration address phase one cycle later. A lock flag that is lost, or set too early, only becomes visible when a second qualifying write is attempted. For this reason the stimulus tries rejected writes both before and after a valid load. It also tries a second load after the first one. The reference model compares both outputs on every clock, so a stale select or a burst phase loaded in error is reported in the cycle it happens.

// File: rtl/cfgid_pkg.sv
package cfgid_pkg;
  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_INTACK = 4'h0;
  localparam logic [CMD_W-1:0] CMD_IO_WR  = 4'h3;
  localparam logic [CMD_W-1:0] CMD_CFG_RD = 4'hA;
  localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'hB;

  // true for either configuration command
  function automatic logic is_cfg_cmd(input logic [CMD_W-1:0] cmd);
    return (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
  endfunction
endpackage

// File: rtl/cfgid_phase_track.sv
module cfgid_phase_track
  import cfgid_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad,
  input  logic [CMD_W-1:0]  cbe_n,
  input  logic              addr_strobe,
  input  logic              data_strobe,
  output logic [CMD_W-1:0]  lat_cmd,
  output logic [DATA_W-1:0] lat_addr,
  output logic              first_data
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cmd  <= CMD_INTACK;
      lat_addr <= '0;
      armed    <= 1'b0;
    end else if (addr_strobe) begin
      lat_cmd  <= cbe_n;
      lat_addr <= ad;
      armed    <= 1'b1;
    end else if (data_strobe) begin
      armed    <= 1'b0;
    end
  end

  // a data phase counts only when it is the first since an address phase
  assign first_data = data_strobe && !addr_strobe && armed;

  // R6
  first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_data |=> !first_data);

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> !first_data);
endmodule

// File: rtl/cfgid_idsel_reg.sv
module cfgid_idsel_reg
  import cfgid_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_ID  = 32'h0200_0000,
  parameter logic [DATA_W-1:0] LOAD_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_data,
  input  logic [CMD_W-1:0]  lat_cmd,
  input  logic [DATA_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] ad,
  input  logic [CMD_W-1:0]  cbe_n,
  output logic [DATA_W-1:0] idsel,
  output logic              locked
);
  function automatic logic exactly_one(input logic [DATA_W-1:0] v);
    int cnt;
    cnt = 0;
    for (int i = 0; i < DATA_W; i++) cnt += int'(v[i]);
    return cnt == 1;
  endfunction

  function automatic logic full_dword(input logic [CMD_W-1:0] be_n);
    return be_n == '0;
  endfunction

  logic load_req;
  logic data_onehot;
  logic load_fire;

  assign load_req    = first_data && (lat_cmd == CMD_IO_WR) &&
                       (lat_addr == LOAD_ADDR) && full_dword(cbe_n);
  assign data_onehot = exactly_one(ad);
  assign load_fire   = load_req && data_onehot && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idsel  <= RESET_ID;
      locked <= 1'b0;
    end else if (load_fire) begin
      idsel  <= ad;
      locked <= 1'b1;
    end
  end

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(idsel));

  // R3
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idsel) |-> $onehot(idsel));

  // R2
  load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idsel) |-> $past(load_req));

  // R4
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(lat_cmd) == CMD_IO_WR) && ($past(cbe_n) == '0));
endmodule

// File: rtl/cfgid_sel_dec.sv
module cfgid_sel_dec
  import cfgid_pkg::*;
#(
  parameter int SEL_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_strobe,
  input  logic [CMD_W-1:0] cbe_n,
  input  logic [SEL_W-1:0] addr_hi,
  input  logic [SEL_W-1:0] id_hi,
  output logic             cfg_sel
);
  function automatic logic lines_match(input logic [SEL_W-1:0] a,
                                       input logic [SEL_W-1:0] id);
    return |(a & id);
  endfunction

  logic cmd_is_cfg;
  logic id_hit;

  assign cmd_is_cfg = is_cfg_cmd(cbe_n);
  assign id_hit     = lines_match(addr_hi, id_hi);

  always_ff @(posedge clk) begin
    if (!rst_n)           cfg_sel <= 1'b0;
    else if (addr_strobe) cfg_sel <= cmd_is_cfg && id_hit;
  end

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_sel) |-> $past(addr_strobe));

  // R7
  sel_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel && $past(addr_strobe)) |-> $past(cmd_is_cfg));

  // R8
  sel_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(addr_strobe) && ($past(id_hi) == '0)) |-> !cfg_sel);
endmodule

// File: rtl/cfgid_select.sv
module cfgid_select
  import cfgid_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                SEL_LSB   = 12,
  parameter logic [DATA_W-1:0] RESET_ID  = 32'h0200_0000,
  parameter logic [DATA_W-1:0] LOAD_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [CMD_W-1:0]  cbe_n_i,
  input  logic              addr_strobe_i,
  input  logic              data_strobe_i,
  output logic [DATA_W-1:0] idsel_o,
  output logic              cfg_sel_o
);
  localparam int SEL_W = DATA_W - SEL_LSB;

  logic [CMD_W-1:0]  lat_cmd;
  logic [DATA_W-1:0] lat_addr;
  logic              first_data;
  logic              locked;

  cfgid_phase_track #(.DATA_W(DATA_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad         (ad_i),
    .cbe_n      (cbe_n_i),
    .addr_strobe(addr_strobe_i),
    .data_strobe(data_strobe_i),
    .lat_cmd    (lat_cmd),
    .lat_addr   (lat_addr),
    .first_data (first_data)
  );

  cfgid_idsel_reg #(
    .DATA_W   (DATA_W),
    .RESET_ID (RESET_ID),
    .LOAD_ADDR(LOAD_ADDR)
  ) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .first_data(first_data),
    .lat_cmd   (lat_cmd),
    .lat_addr  (lat_addr),
    .ad        (ad_i),
    .cbe_n     (cbe_n_i),
    .idsel     (idsel_o),
    .locked    (locked)
  );

  cfgid_sel_dec #(.SEL_W(SEL_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_strobe(addr_strobe_i),
    .cbe_n      (cbe_n_i),
    .addr_hi    (ad_i[DATA_W-1:SEL_LSB]),
    .id_hi      (idsel_o[DATA_W-1:SEL_LSB]),
    .cfg_sel    (cfg_sel_o)
  );

  // R1
  reset_val_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (idsel_o == RESET_ID) && !cfg_sel_o && !locked);
endmodule

// File: tb/tb_cfgid_select.sv
`timescale 1ns/1ps
module tb_cfgid_select;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic        as_s, ds_s;
  logic [31:0] idsel;
  logic        cfg_sel;

  int vectors = 0;
  int miscompares = 0;

  // behavioural reference state
  logic [31:0] m_id;
  logic        m_sel, m_lock, m_arm;
  logic [3:0]  m_cmd;
  logic [31:0] m_addr;

  always #10 clk = ~clk;

  cfgid_select dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe_n),
    .addr_strobe_i(as_s), .data_strobe_i(ds_s),
    .idsel_o(idsel), .cfg_sel_o(cfg_sel)
  );

  task automatic compare(input string tag);
    vectors++;
    if (idsel !== m_id) begin
      miscompares++;
      $display("FAIL %s idsel actual %h expected %h", tag, idsel, m_id);
    end
    if (cfg_sel !== m_sel) begin
      miscompares++;
      $display("FAIL %s cfg_sel actual %b expected %b", tag, cfg_sel, m_sel);
    end
  endtask

  task automatic model_reset();
    m_id = 32'h0200_0000; m_sel = 1'b0; m_lock = 1'b0;
    m_arm = 1'b0; m_cmd = 4'h0; m_addr = '0;
  endtask

  task automatic model_step(input logic a, input logic d,
                            input logic [31:0] v, input logic [3:0] c);
    if (a) begin
      m_sel  = ((c == 4'hA) || (c == 4'hB)) && ((v[31:12] & m_id[31:12]) != 0);
      m_cmd  = c;
      m_addr = v;
      m_arm  = 1'b1;
    end else if (d) begin
      if (m_arm && !m_lock && m_cmd == 4'h3 && m_addr == 0 && c == 4'h0 &&
          $countones(v) == 1) begin
        m_id   = v;
        m_lock = 1'b1;
      end
      m_arm = 1'b0;
    end
  endtask

  // drive on the falling edge, let the rising edge act, compare at the next fall
  task automatic step(input logic a, input logic d, input logic [31:0] v,
                      input logic [3:0] c, input string tag);
    as_s = a; ds_s = d; ad = v; cbe_n = c;
    @(posedge clk);
    model_step(a, d, v, c);
    @(negedge clk);
    compare(tag);
    as_s = 1'b0; ds_s = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; as_s = 1'b0; ds_s = 1'b0; ad = '0; cbe_n = 4'hF;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step(1'b0, 1'b0, 32'h0, 4'hF, "R1");
  endtask

  task automatic io_write(input logic [31:0] addr, input logic [3:0] cmd,
                          input logic [31:0] data, input logic [3:0] be_n,
                          input string tag);
    step(1'b1, 1'b0, addr, cmd, tag);
    step(1'b0, 1'b1, data, be_n, tag);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R7: select against the reset identity
    step(1'b1, 1'b0, 32'h0200_0000, 4'hA, "R7");
    step(1'b0, 1'b0, 32'h0, 4'hF, "R7");
    step(1'b1, 1'b0, 32'h0100_0000, 4'hB, "R7");
    step(1'b1, 1'b0, 32'h0200_0000, 4'h2, "R7");
    step(1'b1, 1'b0, 32'hFFFF_FFFF, 4'hA, "R7");
    step(1'b0, 1'b1, 32'h0000_1234, 4'h0, "R7");
    step(1'b0, 1'b0, 32'h0, 4'hF, "R7");

    // R3: data that is not one-hot
    io_write(32'h0, 4'h3, 32'h0000_0000, 4'h0, "R3");
    io_write(32'h0, 4'h3, 32'h0000_3000, 4'h0, "R3");
    io_write(32'h0, 4'h3, 32'hFFFF_FFFF, 4'h0, "R3");

    // R4: wrong address, partial lanes, wrong command
    io_write(32'h4, 4'h3, 32'h0000_1000, 4'h0, "R4");
    io_write(32'h0, 4'h3, 32'h0000_1000, 4'h1, "R4");
    io_write(32'h0, 4'h3, 32'h0000_1000, 4'h8, "R4");
    io_write(32'h0, 4'h7, 32'h0000_1000, 4'h0, "R4");
    io_write(32'h0, 4'hB, 32'h0000_1000, 4'h0, "R4");

    // R6: later burst phase, and a data strobe overlapping an address strobe
    io_write(32'h0, 4'h3, 32'h0000_0003, 4'h0, "R6");
    step(1'b0, 1'b1, 32'h0000_1000, 4'h0, "R6");
    step(1'b1, 1'b0, 32'h0, 4'h3, "R6");
    step(1'b1, 1'b1, 32'h0000_1000, 4'h0, "R6");
    step(1'b0, 1'b1, 32'h0000_1000, 4'h0, "R6");

    // R2: valid load after all the rejected attempts
    io_write(32'h0, 4'h3, 32'h0000_1000, 4'h0, "R2");
    step(1'b1, 1'b0, 32'h0000_1000, 4'hA, "R2");
    step(1'b1, 1'b0, 32'h0200_0000, 4'hB, "R2");

    // R5: further loads are ignored
    io_write(32'h0, 4'h3, 32'h0800_0000, 4'h0, "R5");
    step(1'b1, 1'b0, 32'h0800_0000, 4'hA, "R5");
    step(1'b1, 1'b0, 32'h0000_1000, 4'hB, "R5");

    // R8: a low bit never selects
    do_reset();
    io_write(32'h0, 4'h3, 32'h0000_0020, 4'h0, "R2");
    step(1'b1, 1'b0, 32'hFFFF_FFFF, 4'hA, "R8");
    step(1'b1, 1'b0, 32'h0200_0000, 4'hB, "R8");
    step(1'b1, 1'b0, 32'h0000_0FFF, 4'hA, "R8");

    // R2: load of the top bit after a fresh reset
    do_reset();
    io_write(32'h0, 4'h3, 32'h8000_0000, 4'h0, "R2");
    step(1'b1, 1'b0, 32'h8000_0000, 4'hB, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 100000);
    miscompares++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule